// File: doc/BRIEF.md
# Memory Operand Offset and Segment Former

This unit turns an operand reference into an address. A decoder supplies the memory addressing form, the four pointer registers (two base, two index), a displacement with a flag for its width, and an optional segment override. In one clock the unit adds up the parts the chosen form uses and produces the 16-bit offset. It also picks which of four segment registers applies. It then combines that segment with the offset into a 20-bit physical address.

All results are registered, so they appear one clock after the request. An unused addressing-form code produces no valid result. The caller drives the request, waits one cycle, and takes the offset, segment choice and physical address while `outValid` is high.

Top module: `eag_top`

## Requirements
- R1: While `rstN` is low, `outValid`, `offset`, `segSel` and `physAddr` are all zero.
- R2: `outValid` is high in the cycle after a request with `inValid` high and `addrMode` from 0 to 5. The results of that request are shown in the same cycle. Otherwise `outValid` is low in the cycle after.
- R3: `addrMode` 0 (direct) gives an offset equal to the extended displacement.
- R4: `addrMode` 1 (pointer only) gives an offset equal to one register, chosen by `regSel`: 0 = first base, 1 = stack base, 2 = first index, 3 = second index.
- R5: `addrMode` 2 (base plus displacement) adds the stack base when `baseIsBp` is 1, or the first base when it is 0, to the extended displacement.
- R6: `addrMode` 3 (index plus displacement) adds the second index when `indexIsDi` is 1, or the first index when it is 0, to the extended displacement.
- R7: `addrMode` 4 adds the selected base and the selected index, with no displacement.
- R8: `addrMode` 5 adds the selected base, the selected index and the extended displacement.
- R9: When `dispWide` is 0, only `disp[7:0]` is used, sign-extended to 16 bits, and `disp[15:8]` has no effect. When `dispWide` is 1, all 16 bits are used.
- R10: The offset sum wraps modulo 2^16.
- R11: With no override, `segSel` is 1 (stack) when the stack base register takes part in the sum. Otherwise it is 0 (data). Code 2 is code and code 3 is extra.
- R12: When `ovrValid` is 1, `segSel` equals `ovrSeg`, whatever the default would be.
- R13: `physAddr` equals the selected segment register times 16 plus the offset, modulo 2^20.
- R14: `addrMode` codes 6 and 7 are rejected: `outValid` is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request present |
| addrMode | input | 3 | Addressing form code 0..5 |
| regSel | input | 2 | Register choice for pointer-only form |
| baseIsBp | input | 1 | Use the stack base instead of the first base |
| indexIsDi | input | 1 | Use the second index instead of the first index |
| disp | input | 16 | Displacement |
| dispWide | input | 1 | 1 = 16-bit displacement, 0 = 8-bit sign-extended |
| regBx | input | 16 | First base register |
| regBp | input | 16 | Stack base register |
| regSi | input | 16 | First index register |
| regDi | input | 16 | Second index register |
| segData | input | 16 | Data segment register |
| segStack | input | 16 | Stack segment register |
| segCode | input | 16 | Code segment register |
| segExtra | input | 16 | Extra segment register |
| ovrValid | input | 1 | Segment override present |
| ovrSeg | input | 2 | Override segment code |
| outValid | output | 1 | Results valid |
| offset | output | 16 | Operand offset |
| segSel | output | 2 | Selected segment code |
| physAddr | output | 20 | Physical address |

## Verification
There is a single pipeline register. A wrong decode strobe or a wrong segment choice therefore shows up in `offset`, `segSel` or `physAddr` exactly one clock after the request that caused it, and the next request overwrites it. Because of this, every request is compared in its result cycle. The stimulus targets the cases where a fault hides: the sign bit of a short displacement, sums that cross 2^16, physical addresses that cross 2^20, and overrides that disagree with the default segment.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    MODE_DIRECT    = 3'd0,
    MODE_PTR       = 3'd1,
    MODE_BASE_DISP = 3'd2,
    MODE_IDX_DISP  = 3'd3,
    MODE_BASE_IDX  = 3'd4,
    MODE_FULL      = 3'd5
  } addrMode_e;

  typedef enum logic [1:0] {
    SEG_DATA  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_CODE  = 2'd2,
    SEG_EXTRA = 2'd3
  } segCode_e;

  typedef struct packed {
    logic     legal;
    logic     addBase;
    logic     baseBp;
    logic     addIndex;
    logic     indexDi;
    logic     addDisp;
    segCode_e seg;
  } eagStrobe_t;
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic [2:0]  addrMode,
  input  logic [1:0]  regSel,
  input  logic        baseIsBp,
  input  logic        indexDi,
  input  logic        ovrValid,
  input  logic [1:0]  ovrSeg,
  output eagStrobe_t  strobe
);
  eagStrobe_t dec;

  always_comb begin
    dec = '0;
    dec.legal = 1'b1;
    case (addrMode_e'(addrMode))
      MODE_DIRECT: dec.addDisp = 1'b1;
      MODE_PTR: begin
        dec.addBase  = ~regSel[1];
        dec.baseBp   = ~regSel[1] & regSel[0];
        dec.addIndex = regSel[1];
        dec.indexDi  = regSel[1] & regSel[0];
      end
      MODE_BASE_DISP: begin
        dec.addBase = 1'b1;
        dec.baseBp  = baseIsBp;
        dec.addDisp = 1'b1;
      end
      MODE_IDX_DISP: begin
        dec.addIndex = 1'b1;
        dec.indexDi  = indexDi;
        dec.addDisp  = 1'b1;
      end
      MODE_BASE_IDX, MODE_FULL: begin
        dec.addBase  = 1'b1;
        dec.baseBp   = baseIsBp;
        dec.addIndex = 1'b1;
        dec.indexDi  = indexDi;
        dec.addDisp  = (addrMode_e'(addrMode) == MODE_FULL);
      end
      default: dec.legal = 1'b0;
    endcase
  end

  always_comb begin
    strobe = dec;
    if (ovrValid) strobe.seg = segCode_e'(ovrSeg);
    else          strobe.seg = (dec.addBase && dec.baseBp) ? SEG_STACK : SEG_DATA;
  end
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int OFS_W        = 16,
  parameter int DISP_SHORT_W = 8,
  parameter int SEG_SHIFT    = 4,
  localparam int PHYS_W      = OFS_W + SEG_SHIFT,
  localparam int SEG_N       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  eagStrobe_t        strobe,
  input  logic [OFS_W-1:0]  disp,
  input  logic              dispWide,
  input  logic [OFS_W-1:0]  regBx,
  input  logic [OFS_W-1:0]  regBp,
  input  logic [OFS_W-1:0]  regSi,
  input  logic [OFS_W-1:0]  regDi,
  input  logic [OFS_W-1:0]  segBank [SEG_N],
  output logic              outValid,
  output logic [OFS_W-1:0]  offset,
  output logic [1:0]        segSel,
  output logic [PHYS_W-1:0] physAddr
);
  logic [OFS_W-1:0]  dispExt, baseTerm, indexTerm, dispTerm, sum, segVal;
  logic [PHYS_W-1:0] physNext;

  always_comb begin
    dispExt   = dispWide ? disp :
                {{(OFS_W-DISP_SHORT_W){disp[DISP_SHORT_W-1]}}, disp[DISP_SHORT_W-1:0]};
    baseTerm  = strobe.addBase  ? (strobe.baseBp  ? regBp : regBx) : '0;
    indexTerm = strobe.addIndex ? (strobe.indexDi ? regDi : regSi) : '0;
    dispTerm  = strobe.addDisp  ? dispExt : '0;
    sum       = baseTerm + indexTerm + dispTerm;
    segVal    = segBank[strobe.seg];
    physNext  = {segVal, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, sum};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      offset   <= '0;
      segSel   <= '0;
      physAddr <= '0;
    end else begin
      outValid <= inValid & strobe.legal;
      offset   <= sum;
      segSel   <= strobe.seg;
      physAddr <= physNext;
    end
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  addrMode,
  input  logic [1:0]  regSel,
  input  logic        baseIsBp,
  input  logic        indexIsDi,
  input  logic [15:0] disp,
  input  logic        dispWide,
  input  logic [15:0] regBx,
  input  logic [15:0] regBp,
  input  logic [15:0] regSi,
  input  logic [15:0] regDi,
  input  logic [15:0] segData,
  input  logic [15:0] segStack,
  input  logic [15:0] segCode,
  input  logic [15:0] segExtra,
  input  logic        ovrValid,
  input  logic [1:0]  ovrSeg,
  output logic        outValid,
  output logic [15:0] offset,
  output logic [1:0]  segSel,
  output logic [19:0] physAddr
);
  eagStrobe_t  strobe;
  logic [15:0] segBank [4];

  assign segBank[SEG_DATA]  = segData;
  assign segBank[SEG_STACK] = segStack;
  assign segBank[SEG_CODE]  = segCode;
  assign segBank[SEG_EXTRA] = segExtra;

  eag_ctrl u_ctrl (
    .addrMode (addrMode),
    .regSel   (regSel),
    .baseIsBp (baseIsBp),
    .indexDi  (indexIsDi),
    .ovrValid (ovrValid),
    .ovrSeg   (ovrSeg),
    .strobe   (strobe)
  );

  eag_datapath #(.OFS_W(16), .DISP_SHORT_W(8), .SEG_SHIFT(4)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .disp     (disp),
    .dispWide (dispWide),
    .regBx    (regBx),
    .regBp    (regBp),
    .regSi    (regSi),
    .regDi    (regDi),
    .segBank  (segBank),
    .outValid (outValid),
    .offset   (offset),
    .segSel   (segSel),
    .physAddr (physAddr)
  );
endmodule

// File: rtl/eag_checker.sv
module eag_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [2:0]  addrMode,
  input logic        baseIsBp,
  input logic        indexIsDi,
  input logic [15:0] disp,
  input logic        dispWide,
  input logic [15:0] regBx,
  input logic [15:0] regBp,
  input logic [15:0] regSi,
  input logic [15:0] regDi,
  input logic        ovrValid,
  input logic [1:0]  ovrSeg,
  input logic        outValid,
  input logic [15:0] offset,
  input logic [1:0]  segSel
);
  logic [15:0] fullWide;
  assign fullWide = (baseIsBp ? regBp : regBx) + (indexIsDi ? regDi : regSi) + disp;

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && addrMode <= 3'd5) |=> outValid);
  // R14
  a_r14_illegal_drop: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode > 3'd5) |=> !outValid);
  // R12
  a_r12_override_wins: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ovrValid && addrMode <= 3'd5) |=> (segSel == $past(ovrSeg)));
  // R11
  a_r11_bp_stack: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ovrValid && addrMode == 3'd2 && baseIsBp) |=> (segSel == 2'd1));
  a_r11_no_base_data: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ovrValid && (addrMode == 3'd0 || addrMode == 3'd3)) |=> (segSel == 2'd0));
  // R8
  a_r8_full_sum: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && addrMode == 3'd5 && dispWide) |=> (offset == $past(fullWide)));
endmodule

bind eag_top eag_checker u_chk (.*);

// File: tb/eag_top_tb.sv
module eag_top_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  addrMode = '0;
  logic [1:0]  regSel = '0;
  logic        baseIsBp = 1'b0, indexIsDi = 1'b0, dispWide = 1'b0;
  logic [15:0] disp = '0, regBx = '0, regBp = '0, regSi = '0, regDi = '0;
  logic [15:0] segData = '0, segStack = '0, segCode = '0, segExtra = '0;
  logic        ovrValid = 1'b0;
  logic [1:0]  ovrSeg = '0;
  logic        outValid;
  logic [15:0] offset;
  logic [1:0]  segSel;
  logic [19:0] physAddr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  eag_top u_dut (.*);

  task automatic chk(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: drive has been set; wait one edge and compare
  task automatic step(string tag);
    int d, b, i, o, s, sv, usesBp;
    bit v;
    d = dispWide ? int'(disp) : int'($signed(disp[7:0])) & 32'hFFFF;
    b = baseIsBp ? int'(regBp) : int'(regBx);
    i = indexIsDi ? int'(regDi) : int'(regSi);
    usesBp = 0;
    v = inValid && addrMode < 6;
    case (addrMode)
      3'd0: o = d;
      3'd1: begin
        o = (regSel == 0) ? regBx : (regSel == 1) ? regBp : (regSel == 2) ? regSi : regDi;
        usesBp = (regSel == 1);
      end
      3'd2: begin o = b + d; usesBp = baseIsBp; end
      3'd3: o = i + d;
      3'd4: begin o = b + i; usesBp = baseIsBp; end
      default: begin o = b + i + d; usesBp = baseIsBp; end
    endcase
    o = o % 65536;
    s = ovrValid ? int'(ovrSeg) : (usesBp ? 1 : 0);
    sv = (s == 0) ? segData : (s == 1) ? segStack : (s == 2) ? segCode : segExtra;
    @(negedge clk);
    chk(tag, "outValid", outValid, v);
    if (v) begin
      chk(tag, "offset", offset, o);
      chk(tag, "segSel", segSel, s);
      chk(tag, "physAddr", physAddr, (sv * 16 + o) % (1 << 20));
    end
  endtask

  task automatic setRegs(logic [15:0] bx, logic [15:0] bp, logic [15:0] si, logic [15:0] di);
    regBx = bx; regBp = bp; regSi = si; regDi = di;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    segData = 16'h1000; segStack = 16'h2000; segCode = 16'h3000; segExtra = 16'hF000;
    setRegs(16'h0100, 16'h0200, 16'h0030, 16'h0004);
    inValid = 1'b1; addrMode = 3'd5; dispWide = 1'b1; disp = 16'h1234;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero under reset
    chk("R1", "outValid", outValid, 0);
    chk("R1", "offset", offset, 0);
    chk("R1", "segSel", segSel, 0);
    chk("R1", "physAddr", physAddr, 0);
    rstN = 1'b1;
    inValid = 1'b0;
    step("R2");
    inValid = 1'b1;
    // R3 direct, wide and short
    addrMode = 0; dispWide = 1; disp = 16'h0301; step("R3");
    dispWide = 0; disp = 16'h1280; step("R3");
    // R9: upper bits ignored on short displacement
    disp = 16'hAB80; step("R9");
    disp = 16'h007F; step("R9");
    // R4 all four pointer choices
    for (int k = 0; k < 4; k++) begin addrMode = 1; regSel = 2'(k); step("R4"); end
    // R5 both bases
    addrMode = 2; dispWide = 1; disp = 16'h0010; baseIsBp = 0; step("R5");
    baseIsBp = 1; step("R5");
    // R6 both indexes, short negative displacement
    addrMode = 3; dispWide = 0; disp = 16'h00FE; indexIsDi = 0; step("R6");
    indexIsDi = 1; step("R6");
    // R7
    addrMode = 4; baseIsBp = 0; indexIsDi = 1; step("R7");
    baseIsBp = 1; indexIsDi = 0; step("R7");
    // R8
    addrMode = 5; dispWide = 1; disp = 16'h0400; step("R8");
    // R10 wrap around 2^16
    setRegs(16'hFFF0, 16'hFF00, 16'h0020, 16'h8000);
    addrMode = 4; baseIsBp = 0; indexIsDi = 0; step("R10");
    addrMode = 5; baseIsBp = 1; indexIsDi = 1; disp = 16'h8100; step("R10");
    // R11 defaults
    addrMode = 2; baseIsBp = 1; step("R11");
    addrMode = 3; step("R11");
    // R12 override against both defaults
    ovrValid = 1; ovrSeg = 2'd3; addrMode = 2; baseIsBp = 1; step("R12");
    ovrSeg = 2'd1; addrMode = 0; step("R12");
    ovrSeg = 2'd2; step("R12");
    ovrValid = 0;
    // R13 physical address wraps at 2^20
    segData = 16'hFFFF; addrMode = 0; dispWide = 1; disp = 16'h0020; step("R13");
    // R14 illegal codes
    addrMode = 6; step("R14");
    addrMode = 7; step("R14");
    // random mix
    for (int n = 0; n < 400; n++) begin
      inValid = ($urandom % 8) != 0;
      addrMode = 3'($urandom); regSel = 2'($urandom);
      baseIsBp = 1'($urandom); indexIsDi = 1'($urandom); dispWide = 1'($urandom);
      disp = 16'($urandom);
      setRegs(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      segData = 16'($urandom); segStack = 16'($urandom);
      segCode = 16'($urandom); segExtra = 16'($urandom);
      ovrValid = 1'($urandom); ovrSeg = 2'($urandom);
      step("R13");
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule